// File: doc/BRIEF.md
# Integer to Single-Precision Converter

This block turns a 32-bit integer operand, read either as two's-complement or as an unsigned magnitude, into a packed IEEE-754 single-precision value. It rounds under a selectable mode and reports whether the result lost precision. A conversion starts with a one-cycle `start_i` pulse that carries the operand, the signedness select and a 3-bit rounding code. Two pipeline stages follow. The first takes the magnitude, counts leading zeros and shifts the operand so its top bit is set. The second rounds the 24-bit significand and packs the word. A new operand can be accepted every cycle.

The rounding code can name a fixed mode, or it can defer to a separately supplied dynamic mode. Reserved codes do not produce a number. They complete the handshake with an error indication. Each legal completion also pulses an output that tells the surrounding pipeline that floating-point state was modified.

Top module: `int2sp_conv`

## Requirements
- R1: An operand of zero, in either signedness, yields result 0x00000000 (positive zero) with `inexact_o` low.
- R2: In signed mode, operand 0x80000000 takes a dedicated path and yields sign 1, biased exponent 0x9E and mantissa 0 (0xCF000000), with `inexact_o` low, in every legal mode.
- R3: In signed mode, any other operand with bit 31 set is negated to its magnitude. That magnitude is converted and rounded, and the result sign (bit 31) is 1.
- R4: In unsigned mode the operand is a nonnegative magnitude of up to 2^32-1 and result bit 31 is always 0 (for example 0x80000000 gives 0x4F000000).
- R5: The biased exponent (result bits 30:23) equals 127 plus the bit position of the magnitude's leading one. Magnitudes below 2^24 convert exactly with `inexact_o` low.
- R6: Rounding codes: 000 nearest with ties to even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, 100 nearest with ties away from zero. Directed modes apply to the signed value, not to the magnitude.
- R7: When rounding carries out of the 24-bit significand, the mantissa becomes 0 and the exponent goes up by one (for example 0x01FFFFFF under code 000 gives 0x4C000000).
- R8: `inexact_o` is high exactly when any magnitude bit below the kept 24-bit significand is nonzero.
- R9: Code 111 selects the mode given on `dyn_rm_i`. If that dynamic value is itself 101, 110 or 111, the conversion is illegal.
- R10: Codes 101 and 110, and illegal dynamic modes, complete with `illegal_rm_o` high, result 0, `inexact_o` low and no `fp_dirty_o` pulse.
- R11: `done_o` pulses exactly two clock cycles after each accepted `start_i`. Back-to-back starts produce one completion each, in order.
- R12: `fp_dirty_o` pulses together with `done_o` on every completion that is not illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accepts the operand and controls this cycle |
| opnd_i | input | 32 | Integer operand |
| signed_i | input | 1 | 1: two's-complement operand, 0: unsigned |
| rm_i | input | 3 | Rounding code; 111 defers to `dyn_rm_i` |
| dyn_rm_i | input | 3 | Dynamic rounding mode |
| result_o | output | 32 | Packed single-precision result |
| inexact_o | output | 1 | Result differs from the exact operand |
| illegal_rm_o | output | 1 | Resolved rounding mode is reserved |
| done_o | output | 1 | Result valid pulse |
| fp_dirty_o | output | 1 | Floating-point state modified pulse |

## Verification
The bench builds the converter with its default 32-bit operand width. At that width the most negative signed value, the unsigned maximum and magnitudes up to 2^31 are all reachable, so the special path, rounding carries that push the exponent up to 0x9F, and up to eight discarded bits all occur. Directed operands place ties, values just above a tie and carry-producing patterns under every rounding code. A stream of pseudo-random operands then covers the rest of the range in both signedness modes.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int SIG_W = MAN_W + 1;
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int BIAS  = 127;

  typedef logic [2:0] rmode_t;

  localparam rmode_t RM_NEAR_EVEN = 3'b000;
  localparam rmode_t RM_TO_ZERO   = 3'b001;
  localparam rmode_t RM_DOWN      = 3'b010;
  localparam rmode_t RM_UP        = 3'b011;
  localparam rmode_t RM_NEAR_MAX  = 3'b100;
  localparam rmode_t RM_DYNAMIC   = 3'b111;

  // Resolve the static code against the dynamic one.
  function automatic rmode_t resolve_mode(input rmode_t code, input rmode_t dyn);
    return (code == RM_DYNAMIC) ? dyn : code;
  endfunction

  function automatic logic mode_is_legal(input rmode_t m);
    return (m <= RM_NEAR_MAX);
  endfunction

  // Decide whether the kept significand is bumped by one ulp.
  function automatic logic round_bump(input rmode_t m, input logic neg,
                                      input logic lsb, input logic guard,
                                      input logic sticky);
    logic lost;
    lost = guard | sticky;
    case (m)
      RM_NEAR_EVEN: return guard & (sticky | lsb);
      RM_TO_ZERO:   return 1'b0;
      RM_DOWN:      return neg & lost;
      RM_UP:        return ~neg & lost;
      RM_NEAR_MAX:  return guard;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/i2f_normalize.sv
module i2f_normalize
  import i2f_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] opnd_i,
  input  logic             signed_i,
  output logic             neg_o,
  output logic             zero_o,
  output logic             most_neg_o,
  output logic [INT_W-1:0] norm_o,
  output logic [EXP_W-1:0] exp_o
);

  localparam int LZ_W    = $clog2(INT_W) + 1;
  localparam int TOP_EXP = BIAS + INT_W - 1;

  logic [INT_W-1:0] mag;
  logic [LZ_W-1:0]  lzc;

  function automatic logic [LZ_W-1:0] count_lz(input logic [INT_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (v[i]) n = LZ_W'(INT_W - 1 - i);
    end
    return n;
  endfunction

  always_comb begin
    neg_o      = signed_i & opnd_i[INT_W-1];
    zero_o     = (opnd_i == '0);
    most_neg_o = neg_o & (opnd_i[INT_W-2:0] == '0);
    mag        = neg_o ? (~opnd_i + 1'b1) : opnd_i;
    lzc        = count_lz(mag);
    if (zero_o) begin
      norm_o = '0;
      exp_o  = '0;
    end else if (most_neg_o) begin
      // dedicated path: magnitude is exactly 2^(INT_W-1)
      norm_o = {1'b1, {(INT_W-1){1'b0}}};
      exp_o  = EXP_W'(TOP_EXP);
    end else begin
      norm_o = mag << lzc;
      exp_o  = EXP_W'(TOP_EXP - int'(lzc));
    end
  end

  always_comb begin
    if (!zero_o) begin
      AST_NORM_TOP: assert (norm_o[INT_W-1]) else $error("leading one lost"); // R5
    end
  end

endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] norm_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             neg_i,
  input  rmode_t           mode_i,
  output logic [FP_W-1:0]  packed_o,
  output logic             inexact_o,
  output logic             carry_o
);

  localparam int EXTRA = INT_W - SIG_W;

  logic [SIG_W-1:0] sig;
  logic             guard;
  logic             sticky;
  logic             bump;
  logic [SIG_W:0]   sum;
  logic [EXP_W-1:0] exp_r;
  logic [MAN_W-1:0] man;

  assign sig   = norm_i[INT_W-1 -: SIG_W];
  assign guard = norm_i[EXTRA-1];

  generate
    if (EXTRA >= 2) begin : g_sticky
      assign sticky = |norm_i[EXTRA-2:0];
    end else begin : g_nosticky
      assign sticky = 1'b0;
    end
  endgenerate

  always_comb begin
    bump      = round_bump(mode_i, neg_i, sig[0], guard, sticky);
    sum       = {1'b0, sig} + (SIG_W+1)'(bump);
    carry_o   = sum[SIG_W];
    man       = carry_o ? '0 : sum[MAN_W-1:0];
    exp_r     = exp_i + EXP_W'(carry_o);
    packed_o  = {neg_i, exp_r, man};
    inexact_o = guard | sticky;
  end

  always_comb begin
    AST_NO_OVERFLOW: assert (exp_r != {EXP_W{1'b1}}) else $error("exponent overflow"); // R7
  end

endmodule

// File: rtl/int2sp_conv.sv
module int2sp_conv
  import i2f_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [INT_W-1:0] opnd_i,
  input  logic             signed_i,
  input  logic [2:0]       rm_i,
  input  logic [2:0]       dyn_rm_i,
  output logic [FP_W-1:0]  result_o,
  output logic             inexact_o,
  output logic             illegal_rm_o,
  output logic             done_o,
  output logic             fp_dirty_o
);

  localparam int TOP_EXP = BIAS + INT_W - 1;

  initial begin
    AST_WIDTH_OK: assert (INT_W >= SIG_W + 2) else $error("INT_W too small"); // R5
  end

  // stage 0 combinational
  logic             n_neg, n_zero, n_most_neg;
  logic [INT_W-1:0] n_norm;
  logic [EXP_W-1:0] n_exp;
  rmode_t           mode_sel;

  assign mode_sel = resolve_mode(rm_i, dyn_rm_i);

  i2f_normalize #(.INT_W(INT_W)) u_norm (
    .opnd_i     (opnd_i),
    .signed_i   (signed_i),
    .neg_o      (n_neg),
    .zero_o     (n_zero),
    .most_neg_o (n_most_neg),
    .norm_o     (n_norm),
    .exp_o      (n_exp)
  );

  // stage 1 registers
  logic             s1_v, s1_neg, s1_zero, s1_most_neg, s1_ill;
  rmode_t           s1_mode;
  logic [INT_W-1:0] s1_norm;
  logic [EXP_W-1:0] s1_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v        <= 1'b0;
      s1_neg      <= 1'b0;
      s1_zero     <= 1'b0;
      s1_most_neg <= 1'b0;
      s1_ill      <= 1'b0;
      s1_mode     <= RM_NEAR_EVEN;
      s1_norm     <= '0;
      s1_exp      <= '0;
    end else begin
      s1_v <= start_i;
      if (start_i) begin
        s1_neg      <= n_neg;
        s1_zero     <= n_zero;
        s1_most_neg <= n_most_neg;
        s1_ill      <= ~mode_is_legal(mode_sel);
        s1_mode     <= mode_sel;
        s1_norm     <= n_norm;
        s1_exp      <= n_exp;
      end
    end
  end

  // rounding
  logic [FP_W-1:0] r_packed;
  logic            r_inexact;
  logic            r_carry;

  i2f_round #(.INT_W(INT_W)) u_round (
    .norm_i    (s1_norm),
    .exp_i     (s1_exp),
    .neg_i     (s1_neg),
    .mode_i    (s1_mode),
    .packed_o  (r_packed),
    .inexact_o (r_inexact),
    .carry_o   (r_carry)
  );

  // output stage
  logic quiet;
  assign quiet = s1_ill | s1_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o     <= '0;
      inexact_o    <= 1'b0;
      illegal_rm_o <= 1'b0;
      done_o       <= 1'b0;
      fp_dirty_o   <= 1'b0;
    end else begin
      done_o     <= s1_v;
      fp_dirty_o <= s1_v & ~s1_ill;
      if (s1_v) begin
        result_o     <= quiet ? '0 : r_packed;
        inexact_o    <= quiet ? 1'b0 : r_inexact;
        illegal_rm_o <= s1_ill;
      end
    end
  end

  // assertions
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ##1 done_o) else $error("done latency"); // R11

  AST_ZERO_PLUS: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_zero && !s1_ill) |=> (result_o == '0 && !inexact_o)) else $error("zero path"); // R1

  AST_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_most_neg && !s1_ill) |=>
      (result_o == {1'b1, EXP_W'(TOP_EXP), {MAN_W{1'b0}}} && !inexact_o)) else $error("most negative"); // R2

  AST_UNSIGNED_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !signed_i) |=> ##1 !result_o[FP_W-1]) else $error("unsigned sign"); // R4

  AST_CARRY_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && !quiet && r_carry) |=> (result_o[MAN_W-1:0] == '0 && result_o[FP_W-2:MAN_W] == $past(s1_exp) + 1'b1)) else $error("carry"); // R7

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && illegal_rm_o) |-> (result_o == '0 && !inexact_o && !fp_dirty_o)) else $error("illegal"); // R10

  AST_DIRTY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fp_dirty_o |-> (done_o && !illegal_rm_o)) else $error("dirty"); // R12

endmodule

// File: tb/test_int2sp_conv.sv
module test_int2sp_conv;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] opnd_i = '0;
  logic        signed_i = 1'b0;
  logic [2:0]  rm_i = '0;
  logic [2:0]  dyn_rm_i = '0;
  logic [31:0] result_o;
  logic        inexact_o, illegal_rm_o, done_o, fp_dirty_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        inx;
    logic        ill;
    int          due;
    string       tag;
  } item_t;

  item_t sb[$];

  int2sp_conv i_int2sp_conv (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opnd_i(opnd_i),
    .signed_i(signed_i), .rm_i(rm_i), .dyn_rm_i(dyn_rm_i),
    .result_o(result_o), .inexact_o(inexact_o), .illegal_rm_o(illegal_rm_o),
    .done_o(done_o), .fp_dirty_o(fp_dirty_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference: magnitude by integer arithmetic, rounding by remainder comparison.
  function automatic item_t model(logic [31:0] a, logic sgn, logic [2:0] rm, logic [2:0] dyn);
    item_t it;
    logic [2:0] mode;
    longint v, m, q, rem, half;
    int p, e;
    bit neg, inc;
    it.res = '0; it.inx = 1'b0; it.ill = 1'b0; it.due = 0; it.tag = "";
    mode = (rm == 3'b111) ? dyn : rm;
    if (mode > 3'b100) begin
      it.ill = 1'b1;
      return it;
    end
    v = sgn ? longint'($signed(a)) : longint'({32'h0, a});
    neg = (v < 0);
    m = neg ? -v : v;
    if (m == 0) return it;
    p = 0;
    for (int i = 0; i < 40; i++) if (((m >> i) & 1) != 0) p = i;
    e = 127 + p;
    if (p <= 23) begin
      q = m << (23 - p); rem = 0; half = 1;
    end else begin
      q = m >> (p - 23);
      rem = m & ((longint'(1) << (p - 23)) - 1);
      half = longint'(1) << (p - 24);
    end
    case (mode)
      3'b000: inc = (rem > half) || (rem == half && q[0]);
      3'b001: inc = 0;
      3'b010: inc = neg && rem != 0;
      3'b011: inc = !neg && rem != 0;
      default: inc = (rem >= half) && rem != 0;
    endcase
    q = q + longint'(inc);
    if (q == (longint'(1) << 24)) begin q = q >> 1; e = e + 1; end
    it.res = {neg, 8'(e), q[22:0]};
    it.inx = (rem != 0);
    return it;
  endfunction

  task automatic drive(logic [31:0] a, logic sgn, logic [2:0] rm, logic [2:0] dyn, string tag);
    item_t it;
    it = model(a, sgn, rm, dyn);
    it.due = cyc + 2;
    it.tag = tag;
    sb.push_back(it);
    start_i = 1'b1; opnd_i = a; signed_i = sgn; rm_i = rm; dyn_rm_i = dyn;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    start_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Monitor: pop and compare on every done pulse.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R11: unexpected done, actual result %h expected no completion", result_o);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (result_o !== it.res || inexact_o !== it.inx || illegal_rm_o !== it.ill ||
            fp_dirty_o !== !it.ill || cyc != it.due) begin
          fails++;
          $display("FAIL %s (R11 R12): actual res=%h inx=%b ill=%b dirty=%b cyc=%0d expected res=%h inx=%b ill=%b dirty=%b cyc=%0d",
                   it.tag, result_o, inexact_o, illegal_rm_o, fp_dirty_o, cyc,
                   it.res, it.inx, it.ill, !it.ill, it.due);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    checks++;
    if (done_o !== 1'b0 || result_o !== '0 || fp_dirty_o !== 1'b0 || illegal_rm_o !== 1'b0) begin
      fails++;
      $display("FAIL reset: actual done=%b res=%h dirty=%b expected 0 0 0", done_o, result_o, fp_dirty_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 zero
    drive(32'h0, 1'b1, 3'b000, 3'b000, "R1");
    drive(32'h0, 1'b0, 3'b011, 3'b000, "R1");
    idle(3);
    // R2 most negative, all legal modes
    for (int md = 0; md < 5; md++) drive(32'h8000_0000, 1'b1, 3'(md), 3'b000, "R2");
    idle(3);
    // R3 negatives
    drive(32'hFFFF_FFFF, 1'b1, 3'b000, 3'b000, "R3");
    drive(32'hFEFF_FFFF, 1'b1, 3'b010, 3'b000, "R3");
    drive(32'hFEFF_FFFF, 1'b1, 3'b011, 3'b000, "R3");
    idle(3);
    // R4 unsigned
    drive(32'h8000_0000, 1'b0, 3'b000, 3'b000, "R4");
    for (int md = 0; md < 5; md++) drive(32'hFFFF_FFFF, 1'b0, 3'(md), 3'b000, "R4");
    idle(3);
    // R5 exact range
    drive(32'h0000_0001, 1'b0, 3'b000, 3'b000, "R5");
    drive(32'h00FF_FFFF, 1'b1, 3'b011, 3'b000, "R5");
    drive(32'h0100_0000, 1'b1, 3'b001, 3'b000, "R5");
    drive(32'h0000_0400, 1'b0, 3'b010, 3'b000, "R5");
    idle(3);
    // R6 R8 ties and near-ties
    for (int md = 0; md < 5; md++) begin
      drive(32'h0100_0001, 1'b1, 3'(md), 3'b000, "R6");
      drive(32'h0100_0003, 1'b1, 3'(md), 3'b000, "R6");
      drive(32'hFEFF_FFFF, 1'b1, 3'(md), 3'b000, "R8");
      drive(32'h1234_5681, 1'b0, 3'(md), 3'b000, "R8");
    end
    idle(3);
    // R7 carry
    drive(32'h01FF_FFFF, 1'b0, 3'b000, 3'b000, "R7");
    drive(32'h01FF_FFFF, 1'b0, 3'b001, 3'b000, "R7");
    drive(32'h7FFF_FFFF, 1'b1, 3'b100, 3'b000, "R7");
    idle(3);
    // R9 dynamic
    drive(32'h01FF_FFFF, 1'b0, 3'b111, 3'b001, "R9");
    drive(32'h0100_0001, 1'b0, 3'b111, 3'b100, "R9");
    drive(32'h0000_0005, 1'b0, 3'b111, 3'b101, "R9");
    drive(32'h0000_0005, 1'b0, 3'b111, 3'b111, "R9");
    idle(3);
    // R10 reserved codes
    drive(32'h0000_0007, 1'b1, 3'b101, 3'b000, "R10");
    drive(32'hFFFF_0000, 1'b1, 3'b110, 3'b000, "R10");
    idle(3);
    // R11 R12 back-to-back pseudo-random stream
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 300; k++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      drive(lfsr >> (lfsr[4:0] & 5'h0F), lfsr[7], 3'(k % 5), 3'b000, "R12");
      if (k % 37 == 0) idle(1);
    end
    idle(5);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R11: actual %0d pending results expected 0", sb.size());
    end
    summary();
  end

endmodule